// File: doc/BRIEF.md
# Three-Phase RL Filter Current Solver

This block estimates the three grid-side line currents of a series resistor-inductor filter. It runs one discrete-time update each time a step-start pulse arrives. For each phase it takes the converter-side voltage and the measured grid voltage and forms their difference. It then advances the phase current by i[k+1] = A·i[k] + B·(v_conv − v_grid). The coefficients A and B are build-time parameters that already contain the per-unit scaling. The defaults assume a 0.8 Ω / 20 mH filter, a 500 ns step, a 563 V voltage base and a 4 A current base.

Every number is a 32-bit two's-complement fixed-point value with 28 fractional bits, so it covers [-8, 8). All six products of an update go through one pipelined multiplier. A small sequencer issues the products in a fixed order. The three new currents appear together, with a one-cycle valid pulse, a fixed number of clock cycles after the step starts (15 by default, i.e. 150 ns at 100 MHz). This fits inside a 500 ns simulation step that runs in lockstep with the converter model.

Top module: `rl_filter_solver`

## Requirements
- R1: While reset is held, and until the first accepted step, the three current outputs read zero, `i_valid` is low and `overrun` is low.
- R2: Each accepted step sets every phase current to A·i[k] + B·d, where i[k] is that phase's previous output. All values use 32-bit two's complement with 28 fractional bits.
- R3: The difference d = v_conv − v_grid is clamped to the range 0x8000_0000..0x7FFF_FFFF before it is multiplied.
- R4: Each of the two products is rounded by adding 2^27 and shifting right arithmetically by 28 bits, then clamped to the 32-bit range. Their sum is clamped the same way.
- R5: The three phases are computed independently, in the order a, b, c, and the three outputs change in the same clock cycle.
- R6: `i_valid` is high for exactly one cycle, in the 15th cycle after the clock edge that accepted `step_start`. The current outputs do not change in any cycle where `i_valid` is low.
- R7: Voltages are captured on the edge that accepts the step. Later changes to the voltage inputs do not affect that step's result.
- R8: A `step_start` that arrives while a step is in progress is ignored, and it sets `overrun`. `overrun` stays set until reset.
- R9: A `step_start` in the cycle where `i_valid` is high is accepted, so steps can run back to back.
- R10: An asynchronous reset in the middle of a step abandons the step and clears all current state to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| step_start | input | 1 | One-cycle pulse that starts a simulation step |
| v_conv_a | input | 32 | Converter-side voltage, phase a (per unit) |
| v_conv_b | input | 32 | Converter-side voltage, phase b |
| v_conv_c | input | 32 | Converter-side voltage, phase c |
| v_grid_a | input | 32 | Measured grid voltage, phase a (per unit) |
| v_grid_b | input | 32 | Measured grid voltage, phase b |
| v_grid_c | input | 32 | Measured grid voltage, phase c |
| i_a | output | 32 | Estimated line current, phase a (per unit) |
| i_b | output | 32 | Estimated line current, phase b |
| i_c | output | 32 | Estimated line current, phase c |
| i_valid | output | 1 | One-cycle pulse when new currents are presented |
| overrun | output | 1 | Sticky flag: a step start arrived while busy |

## Verification
Two situations can land in the same cycle. The first is the commit of one step and the acceptance of the next: the bench raises `step_start` in the very cycle `i_valid` is high, then checks that the second step chains from the currents just committed and that its pulse comes exactly 15 cycles later. The second is an in-flight step and a fresh start pulse. The bench sends a stray pulse in the middle of a step and changes all six voltages at the same moment, then checks that the pending result still matches the captured voltages, that the pulse timing is unchanged and that `overrun` has latched.

// File: rtl/rlf_pkg.sv
package rlf_pkg;
  localparam int QW = 32;
  localparam int QF = 28;
  localparam int NPHASE = 3;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/rlf_rst_sync.sv
module rlf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/rlf_sequencer.sv
module rlf_sequencer
  import rlf_pkg::*;
#(
  parameter int STEP_CYCLES = 15,
  parameter int NPROD       = 6,
  parameter int CW          = $clog2(STEP_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          accept,
  output logic          issue,
  output logic          commit,
  output logic [CW-1:0] cnt,
  output logic          overrun
);
  localparam logic [CW-1:0] LAST_CNT  = CW'(STEP_CYCLES - 1);
  localparam logic [CW-1:0] NPROD_CNT = CW'(NPROD);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovr_q, ovr_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ovr_d   = ovr_q | (start && (state_q == SEQ_RUN));
    unique case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d = SEQ_RUN;
          cnt_d   = '0;
        end
      end
      SEQ_RUN: begin
        if (cnt_q == LAST_CNT) begin
          state_d = SEQ_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ovr_q   <= ovr_d;
    end
  end

  assign busy    = (state_q == SEQ_RUN);
  assign accept  = start && !busy;
  assign issue   = busy && (cnt_q < NPROD_CNT);
  assign commit  = busy && (cnt_q == LAST_CNT);
  assign cnt     = cnt_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/rlf_mac.sv
module rlf_mac #(
  parameter int W       = 32,
  parameter int F       = 28,
  parameter int MUL_LAT = 3,
  parameter int TW      = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic [TW-1:0]       in_tag,
  input  logic signed [W-1:0] in_x,
  input  logic signed [W-1:0] in_y,
  output logic                out_vld,
  output logic [TW-1:0]       out_tag,
  output logic signed [W-1:0] out_res
);
  localparam int PW   = 2 * W;
  localparam int PSTG = MUL_LAT - 1;
  localparam logic signed [PW-1:0] HALF_LSB = PW'(1) <<< (F - 1);
  localparam logic signed [W-1:0]  Q_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0]  Q_MIN = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0]  x_q, y_q;
  logic                 v0_q;
  logic [TW-1:0]        t0_q;
  logic signed [PW-1:0] xe, ye, prod_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q  <= '0;
      y_q  <= '0;
      v0_q <= 1'b0;
      t0_q <= '0;
    end else begin
      v0_q <= in_vld;
      if (in_vld) begin
        x_q  <= in_x;
        y_q  <= in_y;
        t0_q <= in_tag;
      end
    end
  end

  assign xe     = PW'(x_q);
  assign ye     = PW'(y_q);
  assign prod_c = xe * ye;

  logic signed [PW-1:0] p_q [PSTG];
  logic                 pv_q [PSTG];
  logic [TW-1:0]        pt_q [PSTG];

  for (genvar s = 0; s < PSTG; s++) begin : g_pipe
    logic signed [PW-1:0] p_in;
    logic                 v_in;
    logic [TW-1:0]        t_in;
    if (s == 0) begin : g_head
      assign p_in = prod_c;
      assign v_in = v0_q;
      assign t_in = t0_q;
    end else begin : g_body
      assign p_in = p_q[s-1];
      assign v_in = pv_q[s-1];
      assign t_in = pt_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        p_q[s]  <= '0;
        pv_q[s] <= 1'b0;
        pt_q[s] <= '0;
      end else begin
        pv_q[s] <= v_in;
        if (v_in) begin
          p_q[s]  <= p_in;
          pt_q[s] <= t_in;
        end
      end
    end
  end

  logic signed [PW-1:0] rnd_c, shr_c;
  logic                 fits_c;

  always_comb begin
    rnd_c  = p_q[PSTG-1] + HALF_LSB;
    shr_c  = rnd_c >>> F;
    fits_c = (&shr_c[PW-1:W-1]) || ~(|shr_c[PW-1:W-1]);
    if (fits_c)            out_res = shr_c[W-1:0];
    else if (shr_c[PW-1])  out_res = Q_MIN;
    else                   out_res = Q_MAX;
  end

  assign out_vld = pv_q[PSTG-1];
  assign out_tag = pt_q[PSTG-1];
endmodule

// File: rtl/rl_filter_solver.sv
module rl_filter_solver
  import rlf_pkg::*;
#(
  parameter int W           = QW,
  parameter int F           = QF,
  parameter int STEP_CYCLES = 15,
  parameter int MUL_LAT     = 3,
  parameter logic signed [W-1:0] COEF_A = 32'sd268430087,
  parameter logic signed [W-1:0] COEF_B = 32'sd944562
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_start,
  input  logic signed [W-1:0] v_conv_a,
  input  logic signed [W-1:0] v_conv_b,
  input  logic signed [W-1:0] v_conv_c,
  input  logic signed [W-1:0] v_grid_a,
  input  logic signed [W-1:0] v_grid_b,
  input  logic signed [W-1:0] v_grid_c,
  output logic signed [W-1:0] i_a,
  output logic signed [W-1:0] i_b,
  output logic signed [W-1:0] i_c,
  output logic                i_valid,
  output logic                overrun
);
  localparam int NPH   = NPHASE;
  localparam int NPROD = 2 * NPH;
  localparam int TW    = $clog2(NPROD);
  localparam int CW    = $clog2(STEP_CYCLES);
  localparam logic signed [W-1:0] Q_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] Q_MIN = {1'b1, {(W-1){1'b0}}};

  function automatic logic signed [W-1:0] clamp_wide(input logic signed [W:0] s);
    if (s[W] == s[W-1]) return s[W-1:0];
    else if (s[W])      return Q_MIN;
    else                return Q_MAX;
  endfunction

  logic rst_n_int;
  rlf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_n_int)
  );

  logic          seq_busy, seq_accept, seq_issue, seq_commit;
  logic [CW-1:0] seq_cnt;

  rlf_sequencer #(.STEP_CYCLES(STEP_CYCLES), .NPROD(NPROD), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n_int), .start(step_start),
    .busy(seq_busy), .accept(seq_accept), .issue(seq_issue),
    .commit(seq_commit), .cnt(seq_cnt), .overrun(overrun)
  );

  logic signed [W-1:0] vc_w [NPH];
  logic signed [W-1:0] vg_w [NPH];
  assign vc_w[0] = v_conv_a;
  assign vc_w[1] = v_conv_b;
  assign vc_w[2] = v_conv_c;
  assign vg_w[0] = v_grid_a;
  assign vg_w[1] = v_grid_b;
  assign vg_w[2] = v_grid_c;

  logic signed [W-1:0] diff_q [NPH];
  logic signed [W-1:0] diff_d [NPH];
  logic signed [W-1:0] cur_q  [NPH];
  logic signed [W-1:0] cur_d  [NPH];
  logic signed [W-1:0] nxt_q  [NPH];
  logic signed [W-1:0] nxt_d  [NPH];
  logic signed [W-1:0] acc_q, acc_d;
  logic                vld_q;

  logic [TW-1:0]       op_tag;
  logic signed [W-1:0] op_x, op_y;

  always_comb begin
    op_tag = seq_cnt[TW-1:0];
    op_x   = op_tag[0] ? COEF_B : COEF_A;
    op_y   = '0;
    for (int p = 0; p < NPH; p++) begin
      if (op_tag == TW'(2 * p))     op_y = cur_q[p];
      if (op_tag == TW'(2 * p + 1)) op_y = diff_q[p];
    end
  end

  logic                res_vld;
  logic [TW-1:0]       res_tag;
  logic signed [W-1:0] res_val;

  rlf_mac #(.W(W), .F(F), .MUL_LAT(MUL_LAT), .TW(TW)) u_mac (
    .clk(clk), .rst_n(rst_n_int),
    .in_vld(seq_issue), .in_tag(op_tag), .in_x(op_x), .in_y(op_y),
    .out_vld(res_vld), .out_tag(res_tag), .out_res(res_val)
  );

  always_comb begin
    acc_d  = acc_q;
    diff_d = diff_q;
    nxt_d  = nxt_q;
    cur_d  = cur_q;
    if (seq_accept) begin
      for (int p = 0; p < NPH; p++)
        diff_d[p] = clamp_wide({vc_w[p][W-1], vc_w[p]} - {vg_w[p][W-1], vg_w[p]});
    end
    if (res_vld && !res_tag[0]) acc_d = res_val;
    for (int p = 0; p < NPH; p++) begin
      if (res_vld && (res_tag == TW'(2 * p + 1)))
        nxt_d[p] = clamp_wide({acc_q[W-1], acc_q} + {res_val[W-1], res_val});
    end
    if (seq_commit) cur_d = nxt_q;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      acc_q <= '0;
      vld_q <= 1'b0;
      for (int p = 0; p < NPH; p++) begin
        diff_q[p] <= '0;
        nxt_q[p]  <= '0;
        cur_q[p]  <= '0;
      end
    end else begin
      acc_q  <= acc_d;
      diff_q <= diff_d;
      nxt_q  <= nxt_d;
      cur_q  <= cur_d;
      vld_q  <= seq_commit;
    end
  end

  assign i_a     = cur_q[0];
  assign i_b     = cur_q[1];
  assign i_c     = cur_q[2];
  assign i_valid = vld_q;
endmodule

// File: rtl/rlf_checker.sv
module rlf_checker #(
  parameter int W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                step_start,
  input logic                busy,
  input logic                i_valid,
  input logic                overrun,
  input logic signed [W-1:0] i_a,
  input logic signed [W-1:0] i_b,
  input logic signed [W-1:0] i_c
);
  // R6: the valid pulse lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    i_valid |=> !i_valid);

  // R6: currents hold whenever no pulse is presented
  a_r6_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !i_valid |-> ($stable(i_a) && $stable(i_b) && $stable(i_c)));

  // R5: results appear only as a step finishes
  a_r5_pulse_ends_step: assert property (@(posedge clk) disable iff (!rst_n)
    i_valid |-> ($past(busy) && !busy));

  // R8: a start while busy latches the flag
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (step_start && busy) |=> overrun);

  // R8: the flag is sticky
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R9: a start while idle always begins a step
  a_r9_idle_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (step_start && !busy) |=> busy);
endmodule

bind rl_filter_solver rlf_checker #(.W(W)) u_rlf_checker (
  .clk(clk), .rst_n(rst_n_int), .step_start(step_start), .busy(seq_busy),
  .i_valid(i_valid), .overrun(overrun), .i_a(i_a), .i_b(i_b), .i_c(i_c)
);

// File: tb/test_rl_filter_solver.sv
module test_rl_filter_solver;
  localparam logic signed [31:0] A_N = 32'sd268430087;
  localparam logic signed [31:0] B_N = 32'sd944562;
  localparam logic signed [31:0] A_S = 32'sh7000_0000;
  localparam logic signed [31:0] B_S = 32'sh3000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_start = 1'b0;
  logic signed [31:0] vc [3];
  logic signed [31:0] vg [3];
  logic signed [31:0] na, nb, nc, sa, sb, sc;
  logic nv, nov, sv, sov;

  int n_vec = 0;
  int n_bad = 0;
  logic signed [31:0] exp_n [3];
  logic signed [31:0] exp_s [3];
  bit exp_ovr = 1'b0;

  always #4 clk = ~clk;

  rl_filter_solver i_rl_filter_solver (
    .clk(clk), .rst_n(rst_n), .step_start(step_start),
    .v_conv_a(vc[0]), .v_conv_b(vc[1]), .v_conv_c(vc[2]),
    .v_grid_a(vg[0]), .v_grid_b(vg[1]), .v_grid_c(vg[2]),
    .i_a(na), .i_b(nb), .i_c(nc), .i_valid(nv), .overrun(nov)
  );

  rl_filter_solver #(.COEF_A(A_S), .COEF_B(B_S)) i_sat (
    .clk(clk), .rst_n(rst_n), .step_start(step_start),
    .v_conv_a(vc[0]), .v_conv_b(vc[1]), .v_conv_c(vc[2]),
    .v_grid_a(vg[0]), .v_grid_b(vg[1]), .v_grid_c(vg[2]),
    .i_a(sa), .i_b(sb), .i_c(sc), .i_valid(sv), .overrun(sov)
  );

  function automatic logic signed [31:0] sat32(input longint v);
    if (v > 64'sd2147483647) return 32'sh7FFF_FFFF;
    if (v < -64'sd2147483648) return 32'sh8000_0000;
    return v[31:0];
  endfunction

  function automatic logic signed [31:0] qmul(input logic signed [31:0] x, input logic signed [31:0] y);
    longint p;
    p = longint'(x) * longint'(y);
    return sat32((p + (64'sd1 <<< 27)) >>> 28);
  endfunction

  function automatic logic signed [31:0] model(input logic signed [31:0] a, input logic signed [31:0] b,
                                               input logic signed [31:0] cur, input logic signed [31:0] vcv,
                                               input logic signed [31:0] vgv);
    logic signed [31:0] d;
    d = sat32(longint'(vcv) - longint'(vgv));
    return sat32(longint'(qmul(a, cur)) + longint'(qmul(b, d)));
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic signed [31:0] out_n(input int p);
    return (p == 0) ? na : (p == 1) ? nb : nc;
  endfunction
  function automatic logic signed [31:0] out_s(input int p);
    return (p == 0) ? sa : (p == 1) ? sb : sc;
  endfunction

  task automatic check_currents(input string req);
    for (int p = 0; p < 3; p++) begin
      check(out_n(p) == exp_n[p], req, out_n(p), exp_n[p]);
      check(out_s(p) == exp_s[p], req, out_s(p), exp_s[p]);
    end
  endtask

  // Called at a negedge with inputs set; returns at the negedge where valid is high.
  task automatic do_step(input bit inject, input string req);
    logic signed [31:0] nn [3];
    logic signed [31:0] ns [3];
    for (int p = 0; p < 3; p++) begin
      nn[p] = model(A_N, B_N, exp_n[p], vc[p], vg[p]);
      ns[p] = model(A_S, B_S, exp_s[p], vc[p], vg[p]);
    end
    step_start = 1'b1;
    @(negedge clk);
    step_start = 1'b0;
    for (int c = 1; c <= 14; c++) begin
      @(negedge clk);
      if (inject && c == 5) begin
        step_start = 1'b1;
        for (int p = 0; p < 3; p++) begin
          vc[p] = ~vc[p];
          vg[p] = vg[p] + 32'sh0300_0000;
        end
        exp_ovr = 1'b1;
      end
      if (inject && c == 6) step_start = 1'b0;
    end
    check(!nv && !sv, "R6 no early pulse", nv, 0);
    check_currents("R6 outputs held before pulse");
    @(negedge clk);
    check(nv && sv, "R6 pulse at cycle 15", nv, 1);
    for (int p = 0; p < 3; p++) begin
      exp_n[p] = nn[p];
      exp_s[p] = ns[p];
    end
    check_currents(req);
    check(nov == exp_ovr && sov == exp_ovr, "R8 overrun flag", nov, exp_ovr);
  endtask

  task automatic after_pulse();
    @(negedge clk);
    check(!nv && !sv, "R6 pulse single cycle", nv, 0);
  endtask

  logic signed [31:0] vals [8];

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    vals[0] = 32'sh0000_0000; vals[1] = 32'sh1000_0000;
    vals[2] = 32'shF000_0000; vals[3] = 32'sh0123_4567;
    vals[4] = 32'shFFF0_0001; vals[5] = 32'sh7FFF_FFFF;
    vals[6] = 32'sh8000_0000; vals[7] = 32'sh0800_0000;
    for (int p = 0; p < 3; p++) begin
      vc[p] = '0; vg[p] = '0; exp_n[p] = '0; exp_s[p] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!nv && !sv, "R1 valid low in reset", nv, 0);
    check(!nov && !sov, "R1 overrun low in reset", nov, 0);
    check_currents("R1 currents zero in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_currents("R1 currents zero after reset");
    check(!nv && !nov, "R1 idle after reset", nv, 0);

    // R2 R5: distinct per-phase stimulus
    vc[0] = 32'sh0200_0000; vg[0] = 32'sh0100_0000;
    vc[1] = 32'shFE00_0000; vg[1] = 32'sh0000_0000;
    vc[2] = 32'sh0000_0000; vg[2] = 32'sh0000_0000;
    do_step(1'b0, "R2 R5 first step");
    after_pulse();

    // R2 R3 R4: sweep of value pairs, state carried between steps (R10 continuity)
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        vc[0] = vals[i]; vg[0] = vals[j];
        vc[1] = vals[j]; vg[1] = vals[(i + 3) % 8];
        vc[2] = vals[(i + j) % 8]; vg[2] = vals[i];
        do_step(1'b0, "R2 R3 R4 sweep");
        after_pulse();
      end
    end

    // R9: back-to-back steps, second start in the pulse cycle
    vc[0] = 32'sh0400_0000; vg[0] = 32'shFC00_0000;
    vc[1] = 32'sh0010_0000; vg[1] = 32'sh0020_0000;
    vc[2] = 32'sh7000_0000; vg[2] = 32'sh9000_0000;
    do_step(1'b0, "R9 first of pair");
    vc[0] = 32'shF800_0000; vg[0] = 32'sh0000_1000;
    do_step(1'b0, "R9 chained step");
    after_pulse();
    check(!nov, "R9 back-to-back is not overrun", nov, 0);

    // R7 R8: stray start with changed inputs mid-step
    vc[0] = 32'sh0100_0000; vg[0] = 32'sh0000_0000;
    vc[1] = 32'sh0300_0000; vg[1] = 32'sh0100_0000;
    vc[2] = 32'shFF00_0000; vg[2] = 32'sh0200_0000;
    do_step(1'b1, "R7 R8 captured inputs win");
    after_pulse();
    repeat (5) @(negedge clk);
    check(nov && sov, "R8 overrun sticky", nov, 1);
    check_currents("R8 stray start started nothing");
    do_step(1'b0, "R8 later step normal");
    after_pulse();

    // R10: reset in the middle of a step
    step_start = 1'b1;
    @(negedge clk);
    step_start = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    for (int p = 0; p < 3; p++) begin exp_n[p] = '0; exp_s[p] = '0; end
    exp_ovr = 1'b0;
    check_currents("R10 reset clears currents");
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(!nv && !nov, "R10 no pulse after abandoned step", nv, 0);
    check_currents("R10 currents stay zero");
    vc[0] = 32'sh0100_0000; vg[0] = 32'sh0000_0000;
    do_step(1'b0, "R10 step from zero state");
    after_pulse();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule